// File: doc/BRIEF.md
# Interval Timer Host Port

This block is the byte-wide register front end of a three-channel interval timer. A host drives a 2-bit address, an 8-bit write bus and separate read and write strobes. Addresses 0 to 2 reach the data port of one channel each, and address 3 reaches the shared control port. The block decodes control words and the multi-channel read-back command. For each channel it keeps the access configuration, the byte pointers for reads and writes, a one-shot count latch and a one-shot status latch, and a holding register for the low byte of a two-byte count.

Completed counts leave the block as a registered one-cycle load pulse. Each pulse carries a 16-bit value for its channel. Each channel's mode and BCD flag are also driven out. The counting engines sit outside this block. They return their running count and their OUT level, and the block reads those values when it latches a count or a status, or when it serves a direct read.

Read data is combinational from the address and the block state. A read strobe only moves pointers and releases latches at the clock edge that ends the access. Read and write strobes are never asserted in the same cycle.

Top module: `tmr_host_if`

## Requirements
- R1: Control word layout at address 3: bits 7:6 select the channel (value 3 is a read-back command), bits 5:4 the access mode, bits 3:1 the mode, bit 0 BCD. A stored mode of 6 or 7 becomes 2 or 3. Mode and BCD appear on `mode_o`/`bcd_o` after the write.
- R2: Access mode 0 latches the selected channel's running count and leaves that channel's configuration unchanged.
- R3: A control word with a non-zero access mode returns both byte pointers of that channel to the low byte. This also discards a held low byte.
- R4: Read-back: bit 1, bit 2 and bit 3 select channels 0, 1 and 2. Bit 5 low requests a count latch and bit 4 low requests a status latch, for every selected channel.
- R5: A count latch or status latch request is ignored while that channel still holds an unread value of the same kind.
- R6: The status byte is {OUT, 0, access[1:0], mode[2:0], BCD}, with OUT in bit 7.
- R7: A data read returns a pending status first and clears it. Next it returns a latched count per access mode: low byte only, high byte only, or in word mode the low byte, then the high byte, after which the latch is released.
- R8: With nothing latched, a read returns the live count. Low-only mode gives the low byte and high-only mode the high byte. Word mode alternates, starting with the low byte.
- R9: Data writes: low-only mode loads {0x00, byte}. High-only mode loads {byte, 0x00}. Word mode holds the first byte and loads {second, first} on the second write.
- R10: `load_o` pulses for one cycle, on the written channel only, in the cycle after the write that completes a count, and never otherwise.
- R11: A read at address 3 returns 0x00 and changes no state.
- R12: After reset every channel is in word access mode, mode 0, BCD 0, with pointers at the low byte, no latch pending and no load pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 2 | 0..2 channel data port, 3 control port |
| wr_i | input | 1 | Write strobe, one cycle per byte |
| rd_i | input | 1 | Read strobe, one cycle per byte |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the current address |
| live_cnt_i | input | 16*NCH | Running count of each channel |
| out_i | input | NCH | OUT level of each channel |
| load_o | output | NCH | One-cycle load pulse per channel |
| load_val_o | output | 16*NCH | Assembled count for each channel |
| mode_o | output | 3*NCH | Stored mode of each channel |
| bcd_o | output | NCH | Stored BCD flag of each channel |

## Verification
Most faults in a pointer or a latch flag do not show at once. They appear on the next data read of that channel, as a byte from the wrong half, a stale latched value, or a status byte where a count belongs. The tests therefore read every sequence to its end and also read the byte that follows the end. A lost or duplicated holding byte shows up as a missing or early `load_o` pulse one cycle after the second write. A broken latch-once guard needs a live count that changes between two latch requests before it becomes visible.

// File: rtl/tmr_host_pkg.sv
package tmr_host_pkg;
  localparam int DW = 8;
  localparam int CW = 2 * DW;
  localparam int MW = 3;

  typedef enum logic [1:0] {
    ACC_LATCH = 2'd0,
    ACC_LO    = 2'd1,
    ACC_HI    = 2'd2,
    ACC_WORD  = 2'd3
  } acc_e;

  typedef struct packed {
    acc_e          acc;
    logic [MW-1:0] mode;
    logic          bcd;
  } cfg_t;
endpackage

// File: rtl/tmr_cmd_dec.sv
module tmr_cmd_dec
  import tmr_host_pkg::*;
#(
  parameter int NCH = 3
) (
  input  logic          wr_i,
  input  logic [1:0]    addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [NCH-1:0] cfg_we_o,
  output logic [NCH-1:0] cnt_lat_o,
  output logic [NCH-1:0] sts_lat_o,
  output logic [NCH-1:0] dat_we_o,
  output cfg_t          cfg_o
);
  localparam logic [1:0] CTRL_ADDR = 2'd3;
  localparam logic [1:0] RB_SEL    = 2'd3;

  logic       is_ctrl;
  logic [1:0] sel;
  logic [2:0] mode_raw;

  assign is_ctrl  = wr_i && (addr_i == CTRL_ADDR);
  assign sel      = wdata_i[7:6];
  assign mode_raw = wdata_i[3:1];

  always_comb begin
    cfg_o.acc  = acc_e'(wdata_i[5:4]);
    // modes 6/7 alias onto 2/3
    cfg_o.mode = (mode_raw[2] && mode_raw[1]) ? {1'b0, mode_raw[1:0]} : mode_raw;
    cfg_o.bcd  = wdata_i[0];
  end

  always_comb begin
    cfg_we_o  = '0;
    cnt_lat_o = '0;
    sts_lat_o = '0;
    dat_we_o  = '0;
    for (int c = 0; c < NCH; c++) begin
      dat_we_o[c] = wr_i && (addr_i == 2'(c));
      if (is_ctrl) begin
        if (sel == RB_SEL) begin
          if (wdata_i[c+1]) begin
            cnt_lat_o[c] = !wdata_i[5];
            sts_lat_o[c] = !wdata_i[4];
          end
        end else if (sel == 2'(c)) begin
          if (wdata_i[5:4] == 2'd0) cnt_lat_o[c] = 1'b1;
          else                      cfg_we_o[c]  = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/tmr_chan_port.sv
module tmr_chan_port
  import tmr_host_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  cfg_t          cfg_i,
  input  logic          cnt_lat_i,
  input  logic          sts_lat_i,
  input  logic          dat_we_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rd_i,
  input  logic [CW-1:0] live_i,
  input  logic          out_i,
  output logic [DW-1:0] rbyte_o,
  output logic          load_o,
  output logic [CW-1:0] load_val_o,
  output cfg_t          cfg_o
);
  cfg_t          cfg_q;
  logic          wptr_hi_q, rptr_hi_q;
  logic [DW-1:0] wlow_q;
  logic [CW-1:0] clat_q;
  acc_e          clat_st_q;
  logic          slat_v_q;
  logic [DW-1:0] slat_q;
  logic          load_q;
  logic [CW-1:0] load_val_q;
  logic          clat_pend;

  assign clat_pend = (clat_st_q != ACC_LATCH);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q      <= '{acc: ACC_WORD, mode: '0, bcd: 1'b0};
      wptr_hi_q  <= 1'b0;
      rptr_hi_q  <= 1'b0;
      wlow_q     <= '0;
      clat_q     <= '0;
      clat_st_q  <= ACC_LATCH;
      slat_v_q   <= 1'b0;
      slat_q     <= '0;
      load_q     <= 1'b0;
      load_val_q <= '0;
    end else begin
      load_q <= 1'b0;
      if (cfg_we_i) begin
        cfg_q     <= cfg_i;
        wptr_hi_q <= 1'b0;
        rptr_hi_q <= 1'b0;
      end
      if (dat_we_i) begin
        unique case (cfg_q.acc)
          ACC_LO: begin
            load_q     <= 1'b1;
            load_val_q <= {{DW{1'b0}}, wdata_i};
          end
          ACC_HI: begin
            load_q     <= 1'b1;
            load_val_q <= {wdata_i, {DW{1'b0}}};
          end
          ACC_WORD: begin
            if (!wptr_hi_q) begin
              wlow_q    <= wdata_i;
              wptr_hi_q <= 1'b1;
            end else begin
              load_q     <= 1'b1;
              load_val_q <= {wdata_i, wlow_q};
              wptr_hi_q  <= 1'b0;
            end
          end
          default: ;
        endcase
      end
      if (rd_i) begin
        if (slat_v_q) begin
          slat_v_q <= 1'b0;
        end else if (clat_pend) begin
          clat_st_q <= (clat_st_q == ACC_WORD) ? ACC_HI : ACC_LATCH;
        end else if (cfg_q.acc == ACC_WORD) begin
          rptr_hi_q <= !rptr_hi_q;
        end
      end
      if (cnt_lat_i && !clat_pend) begin
        clat_q    <= live_i;
        clat_st_q <= cfg_q.acc;
      end
      if (sts_lat_i && !slat_v_q) begin
        slat_q   <= {out_i, 1'b0, cfg_q.acc, cfg_q.mode, cfg_q.bcd};
        slat_v_q <= 1'b1;
      end
    end
  end

  always_comb begin
    if (slat_v_q) begin
      rbyte_o = slat_q;
    end else if (clat_pend) begin
      rbyte_o = (clat_st_q == ACC_HI) ? clat_q[CW-1:DW] : clat_q[DW-1:0];
    end else begin
      unique case (cfg_q.acc)
        ACC_HI:   rbyte_o = live_i[CW-1:DW];
        ACC_WORD: rbyte_o = rptr_hi_q ? live_i[CW-1:DW] : live_i[DW-1:0];
        default:  rbyte_o = live_i[DW-1:0];
      endcase
    end
  end

  assign load_o     = load_q;
  assign load_val_o = load_val_q;
  assign cfg_o      = cfg_q;
endmodule

// File: rtl/tmr_host_if.sv
module tmr_host_if
  import tmr_host_pkg::*;
#(
  parameter int NCH = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       addr_i,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic [7:0]       wdata_i,
  output logic [7:0]       rdata_o,
  input  logic [16*NCH-1:0] live_cnt_i,
  input  logic [NCH-1:0]   out_i,
  output logic [NCH-1:0]   load_o,
  output logic [16*NCH-1:0] load_val_o,
  output logic [3*NCH-1:0] mode_o,
  output logic [NCH-1:0]   bcd_o
);
  logic [NCH-1:0] cfg_we, cnt_lat, sts_lat, dat_we, rd_ch;
  cfg_t           cfg_new;
  logic [DW-1:0]  rbyte [NCH];

  tmr_cmd_dec #(.NCH(NCH)) u_dec (
    .wr_i      (wr_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .cfg_we_o  (cfg_we),
    .cnt_lat_o (cnt_lat),
    .sts_lat_o (sts_lat),
    .dat_we_o  (dat_we),
    .cfg_o     (cfg_new)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    cfg_t cfg_cur;
    assign rd_ch[c] = rd_i && (addr_i == 2'(c));
    tmr_chan_port u_ch (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .cfg_we_i   (cfg_we[c]),
      .cfg_i      (cfg_new),
      .cnt_lat_i  (cnt_lat[c]),
      .sts_lat_i  (sts_lat[c]),
      .dat_we_i   (dat_we[c]),
      .wdata_i    (wdata_i),
      .rd_i       (rd_ch[c]),
      .live_i     (live_cnt_i[c*CW +: CW]),
      .out_i      (out_i[c]),
      .rbyte_o    (rbyte[c]),
      .load_o     (load_o[c]),
      .load_val_o (load_val_o[c*CW +: CW]),
      .cfg_o      (cfg_cur)
    );
    assign mode_o[c*MW +: MW] = cfg_cur.mode;
    assign bcd_o[c]           = cfg_cur.bcd;
  end

  always_comb begin
    rdata_o = '0;
    for (int c = 0; c < NCH; c++) begin
      if (addr_i == 2'(c)) rdata_o = rbyte[c];
    end
  end
endmodule

// File: rtl/tmr_host_if_chk.sv
module tmr_host_if_chk #(
  parameter int NCH = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       addr_i,
  input logic             wr_i,
  input logic             rd_i,
  input logic [7:0]       rdata_o,
  input logic [16*NCH-1:0] live_cnt_i,
  input logic [NCH-1:0]   out_i,
  input logic [NCH-1:0]   load_o
);
  for (genvar c = 0; c < NCH; c++) begin : g_ld
    p_load_after_write_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      load_o[c] |-> ($past(wr_i) && ($past(addr_i) == 2'(c))));
  end

  p_load_onehot_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(load_o));

  p_ctrl_write_no_load_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == 2'd3) |=> (load_o == '0));

  p_read_no_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !wr_i) |=> (load_o == '0));

  p_ctrl_read_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == 2'd3) |-> (rdata_o == 8'h00));

  p_idle_read_stable_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(wr_i) && !$past(rd_i) && $stable(addr_i) && $stable(live_cnt_i) && $stable(out_i))
      |-> $stable(rdata_o));
endmodule

bind tmr_host_if tmr_host_if_chk #(.NCH(NCH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .addr_i     (addr_i),
  .wr_i       (wr_i),
  .rd_i       (rd_i),
  .rdata_o    (rdata_o),
  .live_cnt_i (live_cnt_i),
  .out_i      (out_i),
  .load_o     (load_o)
);

// File: tb/tmr_host_if_tb_top.sv
module tmr_host_if_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 3;
  localparam int NVEC = 38;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic [1:0]       addr_i = 2'd0;
  logic             wr_i = 1'b0;
  logic             rd_i = 1'b0;
  logic [7:0]       wdata_i = 8'h00;
  logic [7:0]       rdata_o;
  logic [16*NCH-1:0] live_cnt_i = {16'hE5F6, 16'hC3D4, 16'hA1B2};
  logic [NCH-1:0]   out_i = 3'b101;
  logic [NCH-1:0]   load_o;
  logic [16*NCH-1:0] load_val_o;
  logic [3*NCH-1:0] mode_o;
  logic [NCH-1:0]   bcd_o;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  tmr_host_if #(.NCH(NCH)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_i(wr_i), .rd_i(rd_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .live_cnt_i(live_cnt_i), .out_i(out_i),
    .load_o(load_o), .load_val_o(load_val_o), .mode_o(mode_o), .bcd_o(bcd_o)
  );

  // {rd, addr, data, expected read byte, requirement}
  localparam logic [22:0] VEC [NVEC] = '{
    {1'b1, 2'd0, 8'h00, 8'hB2, 4'd12}, // R12 word mode after reset, R8 low first
    {1'b1, 2'd3, 8'h00, 8'h00, 4'd11}, // R11
    {1'b1, 2'd0, 8'h00, 8'hA1, 4'd11}, // R11 pointer untouched
    {1'b0, 2'd3, 8'h00, 8'h00, 4'd2},  // R2 latch ch0
    {1'b1, 2'd0, 8'h00, 8'hB2, 4'd7},
    {1'b1, 2'd0, 8'h00, 8'hA1, 4'd7},
    {1'b1, 2'd0, 8'h00, 8'hB2, 4'd8},  // R8 latch released
    {1'b1, 2'd0, 8'h00, 8'hA1, 4'd8},
    {1'b0, 2'd3, 8'h50, 8'h00, 4'd1},  // ch1 low only
    {1'b1, 2'd1, 8'h00, 8'hD4, 4'd8},
    {1'b1, 2'd1, 8'h00, 8'hD4, 4'd8},
    {1'b0, 2'd3, 8'hA6, 8'h00, 4'd1},  // ch2 high only, mode 3
    {1'b1, 2'd2, 8'h00, 8'hE5, 4'd8},
    {1'b1, 2'd2, 8'h00, 8'hE5, 4'd8},
    {1'b0, 2'd3, 8'hEC, 8'h00, 4'd4},  // R4 status ch1, ch2
    {1'b1, 2'd1, 8'h00, 8'h10, 4'd6},  // R6
    {1'b1, 2'd1, 8'h00, 8'hD4, 4'd7},
    {1'b1, 2'd2, 8'h00, 8'hA6, 4'd6},
    {1'b1, 2'd2, 8'h00, 8'hE5, 4'd7},
    {1'b0, 2'd3, 8'hEC, 8'h00, 4'd4},
    {1'b0, 2'd3, 8'h73, 8'h00, 4'd3},  // ch1 word, mode 1, bcd
    {1'b0, 2'd3, 8'hE4, 8'h00, 4'd5},  // ignored: ch1 status pending
    {1'b1, 2'd1, 8'h00, 8'h10, 4'd5},  // R5 old status kept
    {1'b1, 2'd1, 8'h00, 8'hD4, 4'd3},  // R3 read pointer reset
    {1'b1, 2'd1, 8'h00, 8'hC3, 4'd8},
    {1'b1, 2'd2, 8'h00, 8'hA6, 4'd6},
    {1'b1, 2'd2, 8'h00, 8'hE5, 4'd8},
    {1'b0, 2'd3, 8'hC2, 8'h00, 4'd4},  // count+status ch0
    {1'b1, 2'd0, 8'h00, 8'hB0, 4'd7},  // R7 status first
    {1'b1, 2'd0, 8'h00, 8'hB2, 4'd4},
    {1'b1, 2'd0, 8'h00, 8'hA1, 4'd4},
    {1'b1, 2'd0, 8'h00, 8'hB2, 4'd8},
    {1'b1, 2'd0, 8'h00, 8'hA1, 4'd8},
    {1'b0, 2'd3, 8'h3E, 8'h00, 4'd1},  // mode 7 -> 3
    {1'b0, 2'd3, 8'hE2, 8'h00, 4'd4},
    {1'b1, 2'd0, 8'h00, 8'hB6, 4'd1},  // R1 normalised mode in status
    {1'b1, 2'd0, 8'h00, 8'hB2, 4'd3},
    {1'b1, 2'd0, 8'h00, 8'hA1, 4'd8}
  };

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input int req, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic do_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic do_rd(input logic [1:0] a, input logic [7:0] exp, input int req);
    @(negedge clk_i);
    addr_i = a; rd_i = 1'b1;
    #1;
    check(16'(rdata_o), 16'(exp), req, "read byte");
    @(negedge clk_i);
    rd_i = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(16'(load_o), 16'h0, 12, "R12 no load after reset");
    check(16'(mode_o), 16'h0, 12, "R12 modes after reset");

    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][22]) do_rd(VEC[i][21:20], VEC[i][11:4], int'(VEC[i][3:0]));
      else            do_wr(VEC[i][21:20], VEC[i][19:12]);
    end

    // R1 mode and BCD outputs
    check(16'(mode_o[5:3]), 16'd1, 1, "R1 ch1 mode");
    check(16'(bcd_o[1]), 16'd1, 1, "R1 ch1 bcd");
    check(16'(mode_o[2:0]), 16'd3, 1, "R1 ch0 mode 7 aliased");

    // R9/R10 word write on ch0
    do_wr(2'd0, 8'h34);
    check(16'(load_o), 16'h0, 10, "R10 no load after first byte");
    do_wr(2'd0, 8'h12);
    check(16'(load_o), 16'h1, 10, "R10 load after second byte");
    check(load_val_o[15:0], 16'h1234, 9, "R9 word value");
    @(negedge clk_i);
    check(16'(load_o), 16'h0, 10, "R10 single-cycle pulse");

    // R9 high only on ch2
    do_wr(2'd2, 8'h9C);
    check(16'(load_o), 16'h4, 10, "R10 ch2 load");
    check(load_val_o[47:32], 16'h9C00, 9, "R9 high-only value");

    // R9 low only on ch1
    do_wr(2'd3, 8'h50);
    do_wr(2'd1, 8'h7F);
    check(16'(load_o), 16'h2, 10, "R10 ch1 load");
    check(load_val_o[31:16], 16'h007F, 9, "R9 low-only value");

    // R3 control word discards a held low byte
    do_wr(2'd0, 8'h55);
    do_wr(2'd3, 8'h30);
    do_wr(2'd0, 8'h11);
    check(16'(load_o), 16'h0, 3, "R3 write pointer back at low");
    do_wr(2'd0, 8'h22);
    check(load_val_o[15:0], 16'h2211, 3, "R3 value after pointer reset");

    // R5 second count latch ignored while first unread
    do_wr(2'd3, 8'h00);
    live_cnt_i[15:0] = 16'h0F0E;
    do_wr(2'd3, 8'h00);
    do_rd(2'd0, 8'hB2, 5);
    do_rd(2'd0, 8'hA1, 5);
    do_rd(2'd0, 8'h0E, 8);
    do_rd(2'd0, 8'h0F, 8);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule